// File: doc/BRIEF.md
# Two-Wire Register Access Target

This block is the target side of a two-wire serial register port. An external controller uses it to reach a small bank of 8-bit registers. The clock line and the data line are sampled by a fast system clock. The block finds bus starts and stops in those samples, checks the 7-bit device address, and latches an 8-bit register pointer. After that it either takes a burst of data bytes or returns one byte after a repeated start. The data line is only ever pulled low, through an output enable.

The register storage sits outside the block. For each accepted data byte, a one-cycle strobe presents the pointer and the byte to it. The pointer is also presented at all times, so that the storage can return the selected register's contents for reads. The pointer keeps its value from one transaction to the next. A read that does not set the pointer first therefore returns the register the pointer was left at.

Top module: `i2c_reg_target`

## Requirements
- R1: A transaction begins only at a START, which is a falling data line while the clock line is high. Bits clocked with no START before them draw no acknowledge. A repeated START at any point restarts address matching.
- R2: The first byte after START holds the device address in bits 7:1 and the direction in bit 0, with 0 meaning write and 1 meaning read. The byte is acknowledged, by pulling the data line low during the ninth clock, only when bits 7:1 equal DEV_ADDR. Otherwise it is not acknowledged and the block stays silent until the next START or STOP.
- R3: In a write, the byte after the device address sets the register pointer. It is acknowledged only when its value is below NUM_REGS. When it is not acknowledged, all later bytes up to the next START or STOP are ignored: no acknowledge and no register write.
- R4: Each data byte that follows the pointer byte in a write is acknowledged. It produces exactly one single-cycle rf_wr_en pulse, with rf_addr equal to the pointer and rf_wdata equal to the byte, received MSB first.
- R5: After each written byte the pointer advances by one, except when it is 0x00. In that case it stays at 0x00, so every byte of the burst goes to register 0.
- R6: A data byte that arrives while the pointer is at or above NUM_REGS is not acknowledged and not written. The rest of the burst is then ignored.
- R7: After a read-direction device address is acknowledged, the block drives the 8 bits of the register selected by the pointer, MSB first. It releases the data line before the controller's ninth-clock response, and the read does not move the pointer.
- R8: A START or STOP in the middle of a byte abandons that byte. No register write comes from it, and the next transaction is handled normally.
- R9: Out of reset, sda_oe and rf_wr_en are 0. sda_oe is never 1 while the controller is driving an address, pointer, data or response bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| rf_wr_en | output | 1 | One-cycle write strobe to the register storage |
| rf_addr | output | 8 | Register pointer, used both as write address and read select |
| rf_wdata | output | 8 | Byte to write |
| rf_rdata | input | 8 | Contents of the register selected by rf_addr |

## Verification
The assertions assume a well-formed bus. The data line changes only while the clock line is low, except at deliberate START and STOP conditions. Each clock-line level lasts many system clocks, so the synchronizer and edge detector see every transition once. The bench drives the bus lines on falling system-clock edges and holds each quarter of a bus bit for ten system clocks. It changes the data line a full quarter after the clock falls, and forms every START, repeated START and STOP with the clock line held high and stable.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

  localparam int REG_AW = 8;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RD_RESP,
    ST_IGNORE
  } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);

  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  // synchronizer chain, idle bus level is high
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe[0] <= 1'b1;
      sda_pipe[0] <= 1'b1;
    end else begin
      scl_pipe[0] <= scl_in;
      sda_pipe[0] <= sda_in;
    end
  end

  generate
    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  endgenerate

  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign sda_s = sda_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign sda_lvl   = sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2A,
  parameter int         NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  output logic              sda_oe,
  output logic              rf_wr_en,
  output logic [REG_AW-1:0] rf_addr,
  output logic [BYTE_W-1:0] rf_wdata,
  input  logic [BYTE_W-1:0] rf_rdata
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] BYTE_DONE = CNT_W'(BYTE_W);

  tgt_state_e        state;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [CNT_W-1:0]  bit_cnt;
  logic              dir_rd;
  logic [REG_AW-1:0] ptr;
  logic              rx_state;
  logic              ptr_valid;
  logic              reg_valid;

  assign rx_state  = (state == ST_DEV) || (state == ST_REG) || (state == ST_WDATA);
  assign ptr_valid = (32'(ptr) < NUM_REGS);
  assign reg_valid = (32'(rx_sh) < NUM_REGS);
  assign rf_addr   = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      rx_sh    <= '0;
      tx_sh    <= '0;
      bit_cnt  <= '0;
      dir_rd   <= 1'b0;
      ptr      <= '0;
      sda_oe   <= 1'b0;
      rf_wr_en <= 1'b0;
      rf_wdata <= '0;
    end else begin
      rf_wr_en <= 1'b0;
      if (bus_stop) begin
        state   <= ST_IDLE;
        sda_oe  <= 1'b0;
        bit_cnt <= '0;
      end else if (bus_start) begin
        state   <= ST_DEV;
        sda_oe  <= 1'b0;
        bit_cnt <= '0;
      end else if (rx_state) begin
        if (scl_rise && bit_cnt != BYTE_DONE) begin
          rx_sh   <= {rx_sh[BYTE_W-2:0], sda_lvl};
          bit_cnt <= bit_cnt + 1'b1;
        end else if (scl_fall && bit_cnt == BYTE_DONE) begin
          bit_cnt <= '0;
          case (state)
            ST_DEV: begin
              if (rx_sh[7:1] == DEV_ADDR) begin
                dir_rd <= rx_sh[0];
                sda_oe <= 1'b1;
                state  <= ST_DEV_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end
            ST_REG: begin
              if (reg_valid) begin
                ptr    <= rx_sh;
                sda_oe <= 1'b1;
                state  <= ST_REG_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end
            default: begin
              if (ptr_valid) begin
                rf_wr_en <= 1'b1;
                rf_wdata <= rx_sh;
                sda_oe   <= 1'b1;
                state    <= ST_WDATA_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end
          endcase
        end
      end else begin
        case (state)
          ST_DEV_ACK: begin
            if (scl_fall) begin
              if (dir_rd) begin
                tx_sh   <= rf_rdata;
                sda_oe  <= ~rf_rdata[BYTE_W-1];
                bit_cnt <= CNT_W'(1);
                state   <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_REG;
              end
            end
          end
          ST_REG_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_WDATA;
            end
          end
          ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              if (ptr != '0) ptr <= ptr + 1'b1;
              state <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (bit_cnt == BYTE_DONE) begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
                state   <= ST_RD_RESP;
              end else begin
                tx_sh   <= {tx_sh[BYTE_W-2:0], 1'b0};
                sda_oe  <= ~tx_sh[BYTE_W-2];
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          ST_RD_RESP: begin
            if (scl_rise) state <= ST_IGNORE;
          end
          default: ;
        endcase
      end
    end
  end

  AST_START_RESTART: assert property (@(posedge clk) disable iff (rst)
    (bus_start && !bus_stop) |=> (state == ST_DEV)); // R1
  AST_STOP_ABORT: assert property (@(posedge clk) disable iff (rst)
    bus_stop |=> (state == ST_IDLE && !sda_oe && !rf_wr_en)); // R8
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |=> !rf_wr_en); // R4
  AST_WR_RANGE: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |-> (32'(rf_addr) < NUM_REGS)); // R6
  AST_PTR_ZERO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rf_wr_en && rf_addr == '0) |=> (rf_addr == '0)); // R5
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WDATA && !$stable(rf_addr)) |-> (rf_addr == $past(rf_addr) + 1'b1)); // R5
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE || state == ST_IGNORE) |-> !sda_oe); // R9

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_reg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  output logic       rf_wr_en,
  output logic [7:0] rf_addr,
  output logic [7:0] rf_wdata,
  input  logic [7:0] rf_rdata
);

  logic sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;

  i2c_line_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .bus_start(bus_start),
    .bus_stop (bus_stop)
  );

  i2c_target_fsm #(
    .DEV_ADDR(DEV_ADDR),
    .NUM_REGS(NUM_REGS)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .bus_start(bus_start),
    .bus_stop (bus_stop),
    .sda_oe   (sda_oe),
    .rf_wr_en (rf_wr_en),
    .rf_addr  (rf_addr),
    .rf_wdata (rf_wdata),
    .rf_rdata (rf_rdata)
  );

endmodule

// File: tb/i2c_reg_target_bench.sv
`timescale 1ns/1ps
module i2c_reg_target_bench;

  localparam logic [6:0] DEV = 7'h2A;
  localparam int NREG = 16;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, rf_wr_en;
  logic [7:0] rf_addr, rf_wdata, rf_rdata;
  logic sda_bus;

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_reg_target #(.DEV_ADDR(DEV), .NUM_REGS(NREG)) u_i2c_reg_target (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_bus), .sda_oe(sda_oe),
    .rf_wr_en(rf_wr_en), .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  // external register storage
  logic [7:0] bank [NREG];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) bank[i] <= 8'(i * 17 + 3);
    end else if (rf_wr_en && 32'(rf_addr) < NREG) begin
      bank[rf_addr] <= rf_wdata;
    end
  end
  assign rf_rdata = (32'(rf_addr) < NREG) ? bank[rf_addr] : 8'h00;

  // reference model state
  int unsigned cmp = 0;
  int unsigned mis = 0;
  logic [7:0] expmem [NREG];
  int model_ptr = 0;
  logic [15:0] wq [$];
  bit quiet = 1'b0;
  bit mon_on = 1'b0;
  logic prev_wr = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    cmp++;
    if (!ok) begin
      mis++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (mon_on) begin
      if (rf_wr_en) begin
        if (wq.size() == 0) begin
          check(1'b0, "R4/R8 unexpected write", {rf_addr, rf_wdata}, 0);
        end else begin
          logic [15:0] e;
          e = wq.pop_front();
          check({rf_addr, rf_wdata} == e, "R4 write addr/data", {rf_addr, rf_wdata}, e);
        end
        check(!prev_wr, "R4 single-cycle strobe", prev_wr, 0);
      end
      if (quiet) check(!sda_oe, "R9 silent during controller bit", sda_oe, 0);
      prev_wr = rf_wr_en;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic b, input bit chk, output logic s);
    sda_m = b;
    wait_clk(Q);
    scl = 1'b1;
    quiet = chk;
    wait_clk(Q);
    s = sda_bus;
    wait_clk(Q);
    quiet = 1'b0;
    scl = 1'b0;
    wait_clk(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_clk(Q);
    scl = 1'b1;   wait_clk(Q);
    sda_m = 1'b0; wait_clk(Q);
    scl = 1'b0;   wait_clk(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_clk(Q);
    scl = 1'b1;   wait_clk(Q);
    sda_m = 1'b1; wait_clk(2 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ackd);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], 1'b1, s);
    bit_cycle(1'b1, 1'b0, s);
    ackd = !s;
  endtask

  task automatic recv_byte(output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      bit_cycle(1'b1, 1'b0, s);
      d = {d[6:0], s};
    end
    bit_cycle(1'b1, 1'b1, s);
  endtask

  // write transaction with model prediction
  task automatic do_write(input logic [6:0] dev, input logic [7:0] reg_a,
                          input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, input int n);
    bit ack, live;
    logic [7:0] dd [3];
    dd[0] = d0; dd[1] = d1; dd[2] = d2;
    bus_start();
    send_byte({dev, 1'b0}, ack);
    check(ack == (dev == DEV), "R2 device address ack", ack, dev == DEV);
    live = (dev == DEV);
    send_byte(reg_a, ack);
    check(ack == (live && reg_a < NREG), "R3 pointer byte ack", ack, live && reg_a < NREG);
    if (live && reg_a < NREG) model_ptr = reg_a; else live = 0;
    for (int k = 0; k < n; k++) begin
      bit exp_ack;
      exp_ack = live && (model_ptr < NREG);
      if (exp_ack) begin
        wq.push_back({8'(model_ptr), dd[k]});
        expmem[model_ptr] = dd[k];
      end
      send_byte(dd[k], ack);
      check(ack == exp_ack, "R4/R6 data byte ack", ack, exp_ack);
      if (exp_ack) begin
        if (model_ptr != 0) model_ptr++;
      end else begin
        live = 0;
      end
    end
    bus_stop();
    check(wq.size() == 0, "R4 writes issued", wq.size(), 0);
  endtask

  task automatic do_read(input bit set_ptr, input logic [7:0] reg_a, input string req);
    bit ack;
    logic [7:0] d;
    bus_start();
    if (set_ptr) begin
      send_byte({DEV, 1'b0}, ack);
      check(ack, "R2 write address ack", ack, 1);
      send_byte(reg_a, ack);
      check(ack, "R3 pointer ack", ack, 1);
      model_ptr = reg_a;
      bus_start();
    end
    send_byte({DEV, 1'b1}, ack);
    check(ack, "R7 read address ack", ack, 1);
    recv_byte(d);
    check(d == expmem[model_ptr], req, d, expmem[model_ptr]);
    bus_stop();
    check(!sda_oe, "R7 released after read", sda_oe, 0);
  endtask

  initial begin
    bit ack;
    logic s;
    for (int i = 0; i < NREG; i++) expmem[i] = 8'(i * 17 + 3);
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    check(!sda_oe && !rf_wr_en, "R9 reset outputs", {sda_oe, rf_wr_en}, 0);
    mon_on = 1'b1;

    // R1: no START, matching address clocked in draws no ack
    scl = 1'b0; wait_clk(Q);
    send_byte({DEV, 1'b0}, ack);
    check(!ack, "R1 no ack without START", ack, 0);
    bus_stop();

    // R4 R5 burst with increment, then read back
    do_write(DEV, 8'd5, 8'hA1, 8'hB2, 8'hC3, 3);
    do_read(1'b0, 8'd0, "R5 pointer left after burst read");
    do_read(1'b1, 8'd6, "R7 read after repeated START");
    do_read(1'b1, 8'd5, "R7 read first burst byte");

    // R5 pointer stays at zero
    do_write(DEV, 8'd0, 8'h11, 8'h22, 8'h33, 3);
    check(expmem[1] == bank[1], "R5 register 1 untouched", bank[1], expmem[1]);
    do_read(1'b1, 8'd0, "R5 zero pointer keeps last byte");
    do_read(1'b0, 8'd0, "R5 pointer still zero");

    // R6 run off the end
    do_write(DEV, 8'(NREG - 2), 8'h5A, 8'hA5, 8'h77, 3);
    do_read(1'b1, 8'(NREG - 1), "R6 last register written");

    // R2 wrong device address, R3 bad pointer
    do_write(7'h15, 8'd2, 8'hEE, 8'hEE, 8'hEE, 2);
    do_write(DEV, 8'(NREG + 3), 8'hEE, 8'hEE, 8'hEE, 2);
    do_read(1'b1, 8'd2, "R2/R3 register 2 unchanged");

    // R8 STOP in mid data byte
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'd3, ack);
    for (int i = 0; i < 4; i++) bit_cycle(1'b0, 1'b1, s);
    bus_stop();
    do_read(1'b1, 8'd3, "R8 STOP abort leaves register");

    // R8 repeated START in mid data byte, then a normal write
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'd4, ack);
    for (int i = 0; i < 5; i++) bit_cycle(1'b1, 1'b1, s);
    model_ptr = 4;
    wq.push_back({8'd9, 8'h3C});
    expmem[9] = 8'h3C;
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    check(ack, "R1 restart address ack", ack, 1);
    send_byte(8'd9, ack);
    send_byte(8'h3C, ack);
    check(ack, "R8 byte after restart ack", ack, 1);
    bus_stop();
    do_read(1'b1, 8'd4, "R8 restart abort leaves register");
    do_read(1'b1, 8'd9, "R8 write after restart");

    check(wq.size() == 0, "R4 all writes seen", wq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, mis);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    cmp++;
    mis++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, mis);
    $finish;
  end

endmodule